// File: doc/BRIEF.md
# Disk Controller Command Register Front End

This block is the memory-mapped register face of a moving-head disk controller. A simple word bus with byte-write support reaches twelve registers: the primary control/status word, word count, memory address, desired sector/track, a second control word, drive status, attention summary, lookahead, head offset, desired and current cylinder, and a memory address extension. Writing the primary control word carries a five-bit function code and a start bit, and the block turns that write into a command.

Housekeeping functions and the search function finish on the write itself. Search copies the desired cylinder into the current cylinder. Read and write functions hand off to a separate transfer engine: the block gives a one-cycle start strobe, a direction, and the word count, disk address, cylinder and physical memory address. It then waits for the engine's done pulse. A finished command raises an interrupt request at level 5, vector 0254 octal, when interrupt enable is set. The request stays up until it is acknowledged.

A two-state controller sequences commands. In `ST_IDLE`, a read or write command takes it to `ST_XFER`. In `ST_XFER`, the done pulse takes it back to `ST_IDLE`. Every other command completes while the controller stays in `ST_IDLE`.

Top module: `dkc_regfront`

## Requirements
- R1: After reset every stored register is 0, `irq_req` is 0 and no transfer is running. The primary control word reads 0x0080 and drive status reads 0x11C0. `irq_level` is 5 and `irq_vector` is 0254 octal (172).
- R2: Word writes and reads reach the registers at these byte offsets (octal): primary control 0, word count 2, memory address 4, sector/track 6, control 2 at 010, drive status 012, attention 016, lookahead 020, offset 032, desired cylinder 034, current cylinder 036, extension 050. Address bit 0 is ignored for word accesses. Any other offset reads 0, and a write to it changes no register.
- R3: Drive status reads as its stored value ORed with 0x11C0, which sets bits 6, 7, 8 and 12. The primary control word always reads with bit 7 (ready) set.
- R4: Primary control word fields: bit 0 start, bits 5:1 function, bit 6 interrupt enable, bit 7 ready, bits 8 and 9 memory address bits 16 and 17, bit 14 transfer error. A command write with start clear stores the written bits unchanged. Function 0 with start set stores the word with start cleared.
- R5: Functions 03, 05, 07, 010 and 011 (the field value in octal, i.e. control words 06, 012, 016, 020 and 022 octal) with start set store the word with bits 5:0 cleared. They complete at once and raise `irq_req` on the next cycle if bit 6 was written as 1. They never pulse `xfer_start`.
- R6: Search (field value 014) with start set clears bits 5:0 and loads the current cylinder from the desired cylinder at the same clock edge. It raises the interrupt as in R5.
- R7: Write (field 030) and read (field 034) with start set clear bits 5:0 and pulse `xfer_start` high for exactly the next cycle. `xfer_dir` is 1 for read and 0 for write. The controller moves to `ST_XFER`. A `xfer_done` pulse there clears the word count, returns the controller to `ST_IDLE`, and raises `irq_req` on the next cycle if the stored interrupt enable is set.
- R8: Every command write with start set clears bit 14, except an unsupported function code. An unsupported code with start set stores the word with start cleared and bit 14 set, with no transfer and no interrupt.
- R9: A byte write (`bus_byte`=1, data on `bus_wdata[7:0]`) to offset 1 replaces bits 15:8 of the control word and never dispatches a command. A byte write to offset 0 replaces bits 7:0 and is handled as a full command write. Byte writes to any other register are ignored.
- R10: A command write (word, or byte at offset 0) whose bit 7 is 1 forces the attention register to 1.
- R11: `irq_req` stays high until a cycle with `irq_ack` high, then drops on the following cycle unless a new completion occurs in that same cycle.
- R12: A command write with start set while in `ST_XFER` is stored with start cleared. It dispatches nothing: no strobe, no cylinder load and no interrupt.
- R13: `xfer_addr` equals {control bit 9, control bit 8, memory address} when the extension register is 0. Otherwise it equals {extension bits 5:0, memory address}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | Byte write; data on bus_wdata[7:0] |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| xfer_dir | output | 1 | 1 = disk to memory, 0 = memory to disk |
| xfer_done | input | 1 | Transfer engine completion pulse |
| xfer_wc | output | DATA_W | Word count register |
| xfer_da | output | DATA_W | Desired sector/track register |
| xfer_cyl | output | DATA_W | Desired cylinder register |
| xfer_addr | output | DATA_W+EXT_W | Physical memory address |
| irq_req | output | 1 | Pending interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_level | output | 3 | Interrupt priority level (5) |
| irq_vector | output | 8 | Interrupt vector (0254 octal) |

## Verification
The bench sweeps all 32 function codes with start and interrupt enable set, so it reaches every unsupported code. For each one it works out the expected class, read-back word, strobe and interrupt. A decoder that mistook one code for another would start a transfer, skip an interrupt or leave the error bit wrong. It writes every even offset up to 62, which catches a decoder that aliases a missing register onto a real one. It then exercises the upper/lower byte split: a design that started commands from the upper byte, or that lost the upper bits on a lower-byte write, would show a spurious strobe or a wrong read-back. It also checks that commands are refused while a transfer is running, that the interrupt holds until acknowledged, and that address extension takes precedence over the two legacy address bits across all 64 extension values.

// File: rtl/dkc_pkg.sv
`timescale 1ns/1ps
package dkc_pkg;

    typedef enum logic [3:0] {
        RI_CS1, RI_WC, RI_UBA, RI_DA, RI_CS2, RI_DS,
        RI_AS, RI_LA, RI_OFS, RI_DC, RI_CC, RI_EXT
    } reg_idx_e;

    localparam int NREG = 12;

    // Byte offsets; decoders compare the word part only.
    function automatic logic [5:0] reg_offset(input int idx);
        case (idx)
            0:       return 6'o00;
            1:       return 6'o02;
            2:       return 6'o04;
            3:       return 6'o06;
            4:       return 6'o10;
            5:       return 6'o12;
            6:       return 6'o16;
            7:       return 6'o20;
            8:       return 6'o32;
            9:       return 6'o34;
            10:      return 6'o36;
            default: return 6'o50;
        endcase
    endfunction

    // Control word bit positions
    localparam int B_GO  = 0;
    localparam int B_IE  = 6;
    localparam int B_RDY = 7;
    localparam int B_A16 = 8;
    localparam int B_A17 = 9;
    localparam int B_TRE = 14;
    localparam int FN_LSB = 1;
    localparam int FN_W   = 5;

    // Function field values (bits 5:1)
    localparam logic [FN_W-1:0] FN_HK_A  = 5'o03;
    localparam logic [FN_W-1:0] FN_HK_B  = 5'o05;
    localparam logic [FN_W-1:0] FN_HK_C  = 5'o07;
    localparam logic [FN_W-1:0] FN_HK_D  = 5'o10;
    localparam logic [FN_W-1:0] FN_HK_E  = 5'o11;
    localparam logic [FN_W-1:0] FN_SEEK  = 5'o14;
    localparam logic [FN_W-1:0] FN_WRITE = 5'o30;
    localparam logic [FN_W-1:0] FN_READ  = 5'o34;

    localparam logic [15:0] DS_FORCED = 16'o010700;

    typedef enum logic {ST_IDLE, ST_XFER} ctl_state_e;

    typedef enum logic [2:0] {
        CK_NONE, CK_STORE, CK_ZERO, CK_HOUSE,
        CK_SEEK, CK_XFER, CK_BAD, CK_BUSY
    } cmd_kind_e;

endpackage

// File: rtl/dkc_addr_dec.sv
`timescale 1ns/1ps
module dkc_addr_dec
    import dkc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NREG-1:0]   hit
);
    localparam int WA_W = ADDR_W - 1;

    for (genvar i = 0; i < NREG; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(reg_offset(i));
        assign hit[i] = bus_sel && (bus_addr[ADDR_W-1:1] == OFF[ADDR_W-1:1]);
    end

    initial begin
        assert (WA_W >= 5) else $error("ADDR_W too small for register map");
    end
endmodule

// File: rtl/dkc_regfile.sv
`timescale 1ns/1ps
module dkc_regfile
    import dkc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   hit,
    input  logic              wr_word,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wc_clear,
    input  logic              cc_load,
    input  logic              as_force,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] wc_q,
    output logic [DATA_W-1:0] uba_q,
    output logic [DATA_W-1:0] da_q,
    output logic [DATA_W-1:0] dc_q,
    output logic [DATA_W-1:0] ext_q
);
    localparam logic [DATA_W-1:0] DS_MASK = DATA_W'(DS_FORCED);

    logic [DATA_W-1:0] val [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == int'(RI_CS1)) begin : g_none
            assign val[i] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (i == int'(RI_WC) && wc_clear) begin
                    q <= '0;
                end else if (i == int'(RI_CC) && cc_load) begin
                    q <= val[int'(RI_DC)];
                end else if (i == int'(RI_AS) && as_force) begin
                    q <= DATA_W'(1);
                end else if (wr_word && hit[i]) begin
                    q <= wdata;
                end
            end
            assign val[i] = q;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                rdata = rdata | ((i == int'(RI_DS)) ? (val[i] | DS_MASK) : val[i]);
            end
        end
    end

    assign wc_q  = val[int'(RI_WC)];
    assign uba_q = val[int'(RI_UBA)];
    assign da_q  = val[int'(RI_DA)];
    assign dc_q  = val[int'(RI_DC)];
    assign ext_q = val[int'(RI_EXT)];

    // R6: search copies desired cylinder into current cylinder
    a_r6_cc_from_dc: assert property (@(posedge clk) disable iff (!rst_n)
        cc_load |=> val[int'(RI_CC)] == $past(val[int'(RI_DC)]));

    // R7: completion empties the word count
    a_r7_wc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        wc_clear |=> val[int'(RI_WC)] == '0);

    // R3: drive status always shows the forced bits
    a_r3_ds_forced: assert property (@(posedge clk) disable iff (!rst_n)
        hit[int'(RI_DS)] |-> (rdata & DS_MASK) == DS_MASK);

    // R10: forced attention value
    a_r10_as_one: assert property (@(posedge clk) disable iff (!rst_n)
        as_force |=> val[int'(RI_AS)] == DATA_W'(1));
endmodule

// File: rtl/dkc_cmd_fsm.sv
`timescale 1ns/1ps
module dkc_cmd_fsm
    import dkc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs1_wr_cmd,
    input  logic              cs1_wr_hi,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [7:0]        hi_byte,
    input  logic              xfer_done,
    input  logic              irq_ack,
    output logic [DATA_W-1:0] cs1_q,
    output logic              cc_load,
    output logic              wc_clear,
    output logic              as_force,
    output logic              xfer_start,
    output logic              xfer_dir,
    output logic              irq_req
);
    localparam logic [DATA_W-1:0] CMD_FIELD = DATA_W'(6'h3F);
    localparam logic [DATA_W-1:0] GO_BIT    = DATA_W'(1) << B_GO;
    localparam logic [DATA_W-1:0] TRE_BIT   = DATA_W'(1) << B_TRE;

    ctl_state_e state_q, state_d;
    cmd_kind_e  kind;
    logic [FN_W-1:0]   fn;
    logic [DATA_W-1:0] base;
    logic              irq_set;

    assign fn = cmd_data[FN_LSB +: FN_W];

    // Classify the command write
    always_comb begin
        kind = CK_NONE;
        if (cs1_wr_cmd) begin
            if (!cmd_data[B_GO]) begin
                kind = CK_STORE;
            end else if (fn == '0) begin
                kind = CK_ZERO;
            end else if (state_q == ST_XFER) begin
                kind = CK_BUSY;
            end else begin
                unique case (fn)
                    FN_HK_A, FN_HK_B, FN_HK_C, FN_HK_D, FN_HK_E: kind = CK_HOUSE;
                    FN_SEEK:            kind = CK_SEEK;
                    FN_WRITE, FN_READ:  kind = CK_XFER;
                    default:            kind = CK_BAD;
                endcase
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (kind == CK_XFER) state_d = ST_XFER;
            ST_XFER: if (xfer_done)       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        base = cmd_data;
        if (cmd_data[B_GO]) base = base & ~TRE_BIT;
    end

    assign cc_load  = (kind == CK_SEEK);
    assign wc_clear = (state_q == ST_XFER) && xfer_done;
    assign as_force = cs1_wr_cmd && cmd_data[B_RDY];
    assign irq_set  = (((kind == CK_HOUSE) || (kind == CK_SEEK)) && cmd_data[B_IE])
                    || (wc_clear && cs1_q[B_IE]);

    // Outputs and control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs1_q      <= '0;
            xfer_start <= 1'b0;
            xfer_dir   <= 1'b0;
            irq_req    <= 1'b0;
        end else begin
            xfer_start <= (kind == CK_XFER);
            if (kind == CK_XFER) xfer_dir <= (fn == FN_READ);
            unique case (kind)
                CK_NONE:  if (cs1_wr_hi) cs1_q[DATA_W-1 -: 8] <= hi_byte;
                CK_STORE: cs1_q <= cmd_data;
                CK_ZERO, CK_BUSY: cs1_q <= base & ~GO_BIT;
                CK_HOUSE, CK_SEEK, CK_XFER: cs1_q <= base & ~CMD_FIELD;
                CK_BAD:   cs1_q <= (base & ~GO_BIT) | TRE_BIT;
            endcase
            if (irq_set)      irq_req <= 1'b1;
            else if (irq_ack) irq_req <= 1'b0;
        end
    end

    a_r7_start_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> state_q == ST_XFER);

    a_r7_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && xfer_done) |=> state_q == ST_IDLE);

    a_r11_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req);

    a_r9_hi_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        cs1_wr_hi |=> !xfer_start);

    a_r8_go_clears_tre: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_wr_cmd && cmd_data[B_GO] && kind != CK_BAD) |=> !cs1_q[B_TRE]);

    a_r8_bad_sets_tre: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CK_BAD) |=> (cs1_q[B_TRE] && !xfer_start));

    a_r12_busy_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CK_BUSY) |=> (!xfer_start && !cs1_q[B_GO]));
endmodule

// File: rtl/dkc_regfront.sv
`timescale 1ns/1ps
module dkc_regfront
    import dkc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int EXT_W  = 6,
    parameter logic [2:0] IRQ_LEVEL = 3'd5,
    parameter logic [7:0] IRQ_VEC   = 8'o254
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic                      bus_byte,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      xfer_start,
    output logic                      xfer_dir,
    input  logic                      xfer_done,
    output logic [DATA_W-1:0]         xfer_wc,
    output logic [DATA_W-1:0]         xfer_da,
    output logic [DATA_W-1:0]         xfer_cyl,
    output logic [DATA_W+EXT_W-1:0]   xfer_addr,
    output logic                      irq_req,
    input  logic                      irq_ack,
    output logic [2:0]                irq_level,
    output logic [7:0]                irq_vector
);
    localparam int PHYS_W = DATA_W + EXT_W;
    localparam logic [DATA_W-1:0] RDY_BIT = DATA_W'(1) << B_RDY;

    logic [NREG-1:0]   hit;
    logic              wr_word, byte_lo, byte_hi;
    logic              cs1_wr_cmd, cs1_wr_hi;
    logic [DATA_W-1:0] cmd_data, cs1_q, rf_rdata;
    logic [DATA_W-1:0] uba_q, ext_q;
    logic              cc_load, wc_clear, as_force;
    logic [EXT_W-1:0]  ext_bits;

    dkc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .hit      (hit)
    );

    assign wr_word    = bus_sel && bus_wr && !bus_byte;
    assign byte_lo    = bus_sel && bus_wr && bus_byte && !bus_addr[0];
    assign byte_hi    = bus_sel && bus_wr && bus_byte &&  bus_addr[0];
    assign cs1_wr_cmd = hit[int'(RI_CS1)] && (wr_word || byte_lo);
    assign cs1_wr_hi  = hit[int'(RI_CS1)] && byte_hi;
    assign cmd_data   = bus_byte ? {cs1_q[DATA_W-1:8], bus_wdata[7:0]} : bus_wdata;

    dkc_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs1_wr_cmd (cs1_wr_cmd),
        .cs1_wr_hi  (cs1_wr_hi),
        .cmd_data   (cmd_data),
        .hi_byte    (bus_wdata[7:0]),
        .xfer_done  (xfer_done),
        .irq_ack    (irq_ack),
        .cs1_q      (cs1_q),
        .cc_load    (cc_load),
        .wc_clear   (wc_clear),
        .as_force   (as_force),
        .xfer_start (xfer_start),
        .xfer_dir   (xfer_dir),
        .irq_req    (irq_req)
    );

    dkc_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .wr_word  (wr_word),
        .wdata    (bus_wdata),
        .wc_clear (wc_clear),
        .cc_load  (cc_load),
        .as_force (as_force),
        .rdata    (rf_rdata),
        .wc_q     (xfer_wc),
        .uba_q    (uba_q),
        .da_q     (xfer_da),
        .dc_q     (xfer_cyl),
        .ext_q    (ext_q)
    );

    assign bus_rdata = hit[int'(RI_CS1)] ? (cs1_q | RDY_BIT) : rf_rdata;

    assign ext_bits  = ext_q[EXT_W-1:0];
    assign xfer_addr = (ext_q != '0)
                     ? {ext_bits, uba_q}
                     : {{(EXT_W-2){1'b0}}, cs1_q[B_A17], cs1_q[B_A16], uba_q};

    assign irq_level  = IRQ_LEVEL;
    assign irq_vector = IRQ_VEC;

    // R13: extension register overrides legacy address bits
    a_r13_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_q != '0) |-> xfer_addr[PHYS_W-1:DATA_W] == ext_bits);

    // R3: control word always reads ready
    a_r3_cs1_ready: assert property (@(posedge clk) disable iff (!rst_n)
        hit[int'(RI_CS1)] |-> bus_rdata[B_RDY]);
endmodule

// File: tb/dkc_regfront_tb.sv
`timescale 1ns/1ps
module dkc_regfront_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 0, bus_wr = 0, bus_byte = 0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        xfer_start, xfer_dir, xfer_done = 0;
    logic [15:0] xfer_wc, xfer_da, xfer_cyl;
    logic [21:0] xfer_addr;
    logic        irq_req, irq_ack = 0;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dkc_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .xfer_start(xfer_start), .xfer_dir(xfer_dir),
        .xfer_done(xfer_done), .xfer_wc(xfer_wc), .xfer_da(xfer_da),
        .xfer_cyl(xfer_cyl), .xfer_addr(xfer_addr), .irq_req(irq_req),
        .irq_ack(irq_ack), .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [15:0] d, input logic be);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_byte = be; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_byte = 0;
    endtask

    task automatic bread(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #2 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1;
        @(negedge clk); xfer_done = 0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    function automatic int map_idx(input int off);
        case (off)
            'o02: return 1;  'o04: return 2;  'o06: return 3;  'o10: return 4;
            'o12: return 5;  'o16: return 6;  'o20: return 7;  'o32: return 8;
            'o34: return 9;  'o36: return 10; 'o50: return 11; 'o00: return 0;
            default: return -1;
        endcase
    endfunction

    function automatic logic [15:0] pat(input int off);
        return 16'h2301 ^ (16'(off) * 16'h0505);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic st, ir, dr;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        bread('o00, d); check("R1 cs1 reset", d, 16'h0080);
        bread('o12, d); check("R1 ds reset", d, 16'h11C0);
        bread('o02, d); check("R1 wc reset", d, 0);
        check("R1 irq reset", irq_req, 0);
        check("R1 level", irq_level, 5);
        check("R1 vector", irq_vector, 172);

        // R2/R3: write every mapped plain register, then every unmapped offset
        for (int off = 2; off < 64; off += 2)
            if (map_idx(off) > 0) bwrite(6'(off), pat(off), 0);
        for (int off = 0; off < 64; off += 2)
            if (map_idx(off) < 0) begin
                bwrite(6'(off), 16'hFFFF, 0);
                bread(6'(off), d); check("R2 unmapped reads 0", d, 0);
            end
        for (int off = 2; off < 64; off += 2)
            if (map_idx(off) > 0) begin
                bread(6'(off), d);
                check("R2 R3 mapped readback", d,
                      (off == 'o12) ? (pat(off) | 16'h11C0) : pat(off));
            end
        bread('o03, d); check("R2 odd address word read", d, pat('o02));

        // R4: store without start; function 0 with start
        bwrite('o00, 16'h5A3E, 0);
        bread('o00, d); check("R4 plain store", d, 16'h5ABE);
        bwrite('o00, 16'h0001, 0);
        bread('o00, d); check("R4 fn0 clears go", d, 16'h0080);

        // R10: ready bit written forces attention
        bwrite('o16, 16'h1234, 0);
        bwrite('o00, 16'h0080, 0);
        bread('o16, d); check("R10 attention forced", d, 1);

        // R5-R8 sweep of all function codes with start and enable
        bwrite('o34, 16'h0155, 0);
        for (int fn = 0; fn < 32; fn++) begin
            bit hk, sk, xf, bad;
            hk = (fn == 3 || fn == 5 || fn == 7 || fn == 8 || fn == 9);
            sk = (fn == 12);
            xf = (fn == 24 || fn == 28);
            bad = (fn != 0) && !hk && !sk && !xf;
            bwrite('o36, 16'h0000, 0);
            bwrite('o02, 16'h00F0, 0);
            bwrite('o00, 16'h0041 | 16'(fn << 1), 0);
            st = xfer_start; ir = irq_req; dr = xfer_dir;
            check("R7 R8 start strobe", st, xf);
            check("R5 R6 R8 immediate irq", ir, hk | sk);
            if (xf) check("R7 direction", dr, fn == 28);
            bread('o00, d);
            check("R5 R8 cs1 after cmd", d,
                  bad ? (16'h40C0 | 16'(fn << 1)) : 16'h00C0);
            bread('o36, d); check("R6 current cylinder", d, sk ? 16'h0155 : 16'h0000);
            if (xf) begin
                @(negedge clk); check("R7 start one cycle", xfer_start, 0);
                check("R7 no irq before done", irq_req, 0);
                pulse_done();
                check("R7 irq on done", irq_req, 1);
                bread('o02, d); check("R7 wc cleared", d, 0);
            end
            if (irq_req) begin
                repeat (3) @(negedge clk);
                check("R11 irq held", irq_req, 1);
                pulse_ack();
                check("R11 irq cleared by ack", irq_req, 0);
            end
        end

        // R5: no interrupt when enable clear
        bwrite('o00, 16'h0007, 0);
        check("R5 no irq without enable", irq_req, 0);

        // R12: command while transferring
        bwrite('o36, 16'h0000, 0);
        bwrite('o02, 16'h0005, 0);
        bwrite('o00, 16'h0071, 0);
        check("R7 write starts", xfer_start, 1);
        bwrite('o00, 16'h0059, 0);
        check("R12 busy no start", xfer_start, 0);
        check("R12 busy no irq", irq_req, 0);
        bread('o00, d); check("R12 busy stored go clear", d, 16'h00D8);
        bread('o36, d); check("R12 busy no cyl load", d, 0);
        pulse_done();
        check("R7 irq after busy done", irq_req, 1);
        pulse_ack();

        // R9: byte writes
        bwrite('o00, 16'h0000, 0);
        bwrite('o01, 16'h0071, 1);
        check("R9 upper byte no start", xfer_start, 0);
        bread('o00, d); check("R9 upper byte stored", d, 16'h7180);
        bwrite('o00, 16'h0071, 1);
        check("R9 lower byte dispatches", xfer_start, 1);
        check("R9 lower byte dir write", xfer_dir, 0);
        bread('o00, d); check("R9 merged word", d, 16'h31C0);
        pulse_done(); pulse_ack();
        bwrite('o02, 16'h0033, 1);
        bread('o02, d); check("R9 byte to other reg ignored", d, 0);

        // R13: physical address
        bwrite('o04, 16'hBEEF, 0);
        bwrite('o50, 16'h0000, 0);
        for (int a = 0; a < 4; a++) begin
            bwrite('o00, 16'(a << 8), 0);
            @(negedge clk);
            check("R13 legacy bits", xfer_addr, {4'b0, 2'(a), 16'hBEEF});
        end
        for (int e = 0; e < 64; e++) begin
            bwrite('o50, 16'(e), 0);
            @(negedge clk);
            check("R13 extension", xfer_addr,
                  (e == 0) ? {6'b000011, 16'hBEEF} : {6'(e), 16'hBEEF});
        end
        bwrite('o50, 16'h0100, 0);
        @(negedge clk);
        check("R13 ext nonzero high bits", xfer_addr, {6'b0, 16'hBEEF});

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule